// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block chooses which of up to 22 interrupt sources a small accumulator-style CPU core should service next. It then presents the chosen source as a request, a source index and a call vector address. Each source supplies a pending flag, an enable bit and a priority bit (0 = low, 1 = high). The controller qualifies and decodes these inputs on every clock. A grant is decided only at an instruction boundary. The controller keeps one in-service bit per priority level, so a high-priority handler can interrupt a low-priority one and nothing can interrupt a high-priority handler.

The CPU drives four handshake inputs. `instr_done_i` marks an instruction boundary. `reti_i` marks the boundary at which a return-from-interrupt completes. `call_ack_i` accepts the presented call. `stall_i` freezes granting, for example during flash programming. The controller never clears a pending flag itself. The granted index is output so that a source can clear its own flag in hardware. The vector of source n is 0x0003 + 8·n.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset `irq_o` is 0 and neither priority level is in service, so the first qualified request at a legal boundary is granted at either level.
- R2: A high-priority request (prio bit 1) is granted while a low-priority handler is in service. No request of either level is granted while a high-priority handler is in service.
- R3: Among requests that are eligible in the same cycle, high priority wins over low. Within one level, the lowest source index wins.
- R4: If a qualified request and a legal boundary are present in the same cycle, `irq_o` is 1 from the next clock edge on.
- R5: While `irq_o` is 1, `vec_o` equals 3 + 8·`idx_o`. Bits [2:0] are 3'b011 and the upper bits hold the index, so index 15 gives 0x007B and index 21 gives 0x00AB.
- R6: Source index 20 is reserved and is never granted, even when it is pending and enabled.
- R7: No grant is issued at the boundary on which `reti_i` is 1. The earliest grant after a return comes at the next `instr_done_i`, which is the end of exactly one further instruction.
- R8: A low-priority request is held while a low-priority handler is in service, and is granted only after that handler has returned.
- R9: While `stall_i` is 1, no grant is issued. A request that is still pending is granted at the first legal boundary after the stall ends.
- R10: A grant is issued only in a cycle where `instr_done_i` and `gie_i` are both 1.
- R11: Once raised, `irq_o`, `idx_o` and `vec_o` hold until a cycle with `call_ack_i` = 1. That acknowledge drops `irq_o` and marks the granted level as in service. `call_ack_i` has no effect while `irq_o` is 0.
- R12: `reti_i` clears the high in-service bit if it is set, and otherwise the low one, so nested returns unwind innermost first.
- R13: A source whose enable bit is 0 is never granted, whatever its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NSRC | Pending flag per source |
| en_i | input | NSRC | Enable bit per source |
| prio_i | input | NSRC | Priority bit per source, 1 = high |
| gie_i | input | 1 | Global interrupt enable |
| instr_done_i | input | 1 | Instruction boundary in this cycle |
| reti_i | input | 1 | Return-from-interrupt completes at this boundary |
| call_ack_i | input | 1 | CPU accepts the presented call |
| stall_i | input | 1 | Freeze granting |
| irq_o | output | 1 | Call request to the CPU |
| vec_o | output | VEC_W | Call vector address |
| idx_o | output | IDX_W | Index of the granted source |

## Verification
There is one register between a decision and the outputs. A grant decided from the inputs of a cycle appears on `irq_o`, `idx_o` and `vec_o` right after the next rising edge. An acknowledge or a return changes the in-service state at that same edge, and the change becomes visible through the grant decision of the following cycle. The bench applies each cycle's inputs at the falling edge and advances its own model of the same edge. It compares the outputs 1 ns after the rising edge, so every expectation is checked in the first cycle it is due. Nesting state is observed only through which requests are later granted or held.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  // Call address of a source: fixed base plus a stride per index.
  function automatic logic [31:0] vec_of(input int unsigned idx,
                                         input int unsigned base,
                                         input int unsigned stride);
    return 32'(base + stride * idx);
  endfunction

endpackage

// File: rtl/ivc_qualify.sv
module ivc_qualify #(
  parameter int unsigned NSRC     = 22,
  parameter int unsigned RSVD_IDX = 20
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] prio_i,
  output logic [NSRC-1:0] cand_hi_o,
  output logic [NSRC-1:0] cand_lo_o
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == RSVD_IDX) begin : g_rsvd
      assign cand_hi_o[g] = 1'b0;
      assign cand_lo_o[g] = 1'b0;
    end else begin : g_live
      logic live;
      assign live         = pend_i[g] & en_i[g];
      assign cand_hi_o[g] = live & prio_i[g];
      assign cand_lo_o[g] = live & ~prio_i[g];
    end
  end

endmodule

// File: rtl/ivc_find_first.sv
module ivc_find_first #(
  parameter int unsigned N     = 22,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |vec_i;

endmodule

// File: rtl/ivc_nest.sv
module ivc_nest
  import ivc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_en_i,
  input  lvl_e set_lvl_i,
  input  logic ret_i,
  output logic ins_hi_o,
  output logic ins_lo_o,
  output logic clr_hi_o,
  output logic clr_lo_o
);

  logic hi_q, lo_q, hi_d, lo_d;

  always_comb begin
    clr_hi_o = ret_i & hi_q;
    clr_lo_o = ret_i & ~hi_q & lo_q;
    hi_d = hi_q & ~clr_hi_o;
    lo_d = lo_q & ~clr_lo_o;
    if (set_en_i) begin
      if (set_lvl_i == LVL_HI) hi_d = 1'b1;
      else                     lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign ins_hi_o = hi_q;
  assign ins_lo_o = lo_q;

endmodule

// File: rtl/ivc_grant.sv
module ivc_grant
  import ivc_pkg::*;
#(
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  lvl_e             win_lvl_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VEC_W-1:0] vec_o,
  output lvl_e             lvl_o,
  output logic             ack_fire_o
);

  logic [31:0] vec_full;

  assign vec_full   = vec_of(int'(win_idx_i), VEC_BASE, VEC_STRIDE);
  assign ack_fire_o = irq_o & ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      idx_o <= '0;
      vec_o <= '0;
      lvl_o <= LVL_LO;
    end else if (take_i) begin
      irq_o <= 1'b1;
      idx_o <= win_idx_i;
      vec_o <= vec_full[VEC_W-1:0];
      lvl_o <= win_lvl_i;
    end else if (ack_fire_o) begin
      irq_o <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned NSRC       = 22,
  parameter int unsigned RSVD_IDX   = 20,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  localparam int unsigned IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NSRC-1:0]  en_i,
  input  logic [NSRC-1:0]  prio_i,
  input  logic             gie_i,
  input  logic             instr_done_i,
  input  logic             reti_i,
  input  logic             call_ack_i,
  input  logic             stall_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [NSRC-1:0]  cand_hi, cand_lo;
  logic             found_hi, found_lo;
  logic [IDX_W-1:0] idx_hi, idx_lo;
  logic             ins_hi, ins_lo, clr_hi, clr_lo;
  logic             hi_ok, lo_ok, boundary_ok;
  logic             win_valid, take, ack_fire;
  logic [IDX_W-1:0] win_idx;
  lvl_e             win_lvl, grant_lvl;

  ivc_qualify #(.NSRC(NSRC), .RSVD_IDX(RSVD_IDX)) u_qual (
    .pend_i(pend_i), .en_i(en_i), .prio_i(prio_i),
    .cand_hi_o(cand_hi), .cand_lo_o(cand_lo)
  );

  ivc_find_first #(.N(NSRC), .IDX_W(IDX_W)) u_ff_hi (
    .vec_i(cand_hi), .found_o(found_hi), .idx_o(idx_hi)
  );

  ivc_find_first #(.N(NSRC), .IDX_W(IDX_W)) u_ff_lo (
    .vec_i(cand_lo), .found_o(found_lo), .idx_o(idx_lo)
  );

  // Eligibility: high level blocked only by a high handler, low by either.
  assign hi_ok       = ~ins_hi;
  assign lo_ok       = ~ins_hi & ~ins_lo;
  assign boundary_ok = instr_done_i & gie_i & ~stall_i & ~reti_i;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = idx_lo;
    win_lvl   = LVL_LO;
    if (found_hi && hi_ok) begin
      win_valid = 1'b1;
      win_idx   = idx_hi;
      win_lvl   = LVL_HI;
    end else if (found_lo && lo_ok) begin
      win_valid = 1'b1;
    end
  end

  assign take = boundary_ok & win_valid & ~irq_o;

  ivc_grant #(
    .IDX_W(IDX_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_grant (
    .clk(clk), .rst_n(rst_n), .take_i(take),
    .win_idx_i(win_idx), .win_lvl_i(win_lvl), .ack_i(call_ack_i),
    .irq_o(irq_o), .idx_o(idx_o), .vec_o(vec_o),
    .lvl_o(grant_lvl), .ack_fire_o(ack_fire)
  );

  ivc_nest u_nest (
    .clk(clk), .rst_n(rst_n),
    .set_en_i(ack_fire), .set_lvl_i(grant_lvl), .ret_i(reti_i),
    .ins_hi_o(ins_hi), .ins_lo_o(ins_lo),
    .clr_hi_o(clr_hi), .clr_lo_o(clr_lo)
  );

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned RSVD_IDX = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie_i,
  input logic             instr_done_i,
  input logic             reti_i,
  input logic             call_ack_i,
  input logic             stall_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             ins_hi,
  input logic             ins_lo,
  input logic             clr_hi,
  input logic             clr_lo,
  input logic             grant_lvl
);

  AST_HI_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$past(ins_hi)); // R2
  AST_LO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && !grant_lvl) |-> !$past(ins_lo)); // R8
  AST_VEC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[2:0] == 3'b011 && (vec_o >> 3) == VEC_W'(idx_o))); // R5
  AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (32'(idx_o) != RSVD_IDX)); // R6
  AST_RET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$past(reti_i)); // R7
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$past(stall_i)); // R9
  AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(instr_done_i) && $past(gie_i))); // R10
  AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !call_ack_i) |=> (irq_o && $stable(idx_o) && $stable(vec_o))); // R11
  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && call_ack_i) |=> (!irq_o && ($past(grant_lvl) ? ins_hi : ins_lo))); // R11
  AST_UNWIND_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hi && !(irq_o && call_ack_i)) |=> !ins_hi); // R12
  AST_UNWIND_LO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo |=> (ins_lo == $past(irq_o && call_ack_i && !grant_lvl))); // R12
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_hi, clr_lo})); // R12

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .IDX_W(IDX_W), .VEC_W(VEC_W), .RSVD_IDX(RSVD_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .instr_done_i(instr_done_i),
  .reti_i(reti_i), .call_ack_i(call_ack_i), .stall_i(stall_i),
  .irq_o(irq_o), .vec_o(vec_o), .idx_o(idx_o),
  .ins_hi(ins_hi), .ins_lo(ins_lo), .clr_hi(clr_hi), .clr_lo(clr_lo),
  .grant_lvl(grant_lvl)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;

  localparam int N  = 22;
  localparam int IW = 5;
  localparam int VW = 16;
  localparam int RSVD = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, en = '0, prio = '0;
  logic          gie = 1'b0, idone = 1'b0, reti = 1'b0, ack = 1'b0, stall = 1'b0;
  logic          irq;
  logic [VW-1:0] vec;
  logic [IW-1:0] idx;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state
  bit     m_irq, m_hi, m_lo, m_lvl;
  int     m_idx;

  always #2 clk = ~clk;

  irq_vec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
    .gie_i(gie), .instr_done_i(idone), .reti_i(reti), .call_ack_i(ack),
    .stall_i(stall), .irq_o(irq), .vec_o(vec), .idx_o(idx)
  );

  function automatic int exp_vec(input int i);
    return (i * 8) + 3;
  endfunction

  // Pick by level then ascending index; returns -1 if none eligible.
  function automatic int ref_pick(output bit lvl);
    lvl = 1'b0;
    if (!m_hi) begin
      for (int i = 0; i < N; i++)
        if (i != RSVD && pend[i] && en[i] && prio[i]) begin lvl = 1'b1; return i; end
      if (!m_lo)
        for (int i = 0; i < N; i++)
          if (i != RSVD && pend[i] && en[i] && !prio[i]) return i;
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pend = '0; en = '0; prio = '0;
    gie = 1'b0; idone = 1'b0; reti = 1'b0; ack = 1'b0; stall = 1'b0;
    m_irq = 0; m_hi = 0; m_lo = 0; m_lvl = 0; m_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Inputs set by caller at a falling edge; advance model, compare after edge.
  task automatic tick(input string tag);
    bit lvl, fire;
    int w;
    w = ref_pick(lvl);
    fire = m_irq && ack;
    if (reti) begin
      if (m_hi) m_hi = 0; else m_lo = 0;
    end
    if (fire) begin
      if (m_lvl) m_hi = 1; else m_lo = 1;
    end
    if (!m_irq && idone && gie && !stall && !reti && w >= 0) begin
      m_irq = 1; m_idx = w; m_lvl = lvl;
    end else if (fire) begin
      m_irq = 0;
    end
    @(posedge clk);
    #1;
    check(irq == m_irq, {tag, " irq"}, int'(irq), int'(m_irq));
    if (m_irq) begin
      check(int'(idx) == m_idx, {tag, " idx"}, int'(idx), m_idx);
      check(int'(vec) == exp_vec(m_idx), {tag, " vec"}, int'(vec), exp_vec(m_idx));
    end
    @(negedge clk);
    reti = 1'b0; ack = 1'b0;
  endtask

  task automatic boundary(input string tag);
    idone = 1'b1; tick(tag); idone = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    // R1: idle after reset, then a low request is granted at once
    check(irq == 1'b0, "R1 reset irq", int'(irq), 0);
    en = '1; gie = 1'b1; pend[7] = 1'b1;
    boundary("R1");
    check(irq == 1'b1, "R1 first grant", int'(irq), 1);

    // R10 / R4: no boundary, no global enable, then grant next edge
    do_reset();
    en = '1; pend[3] = 1'b1; gie = 1'b1;
    tick("R10 no boundary");
    check(irq == 1'b0, "R10 no boundary", int'(irq), 0);
    gie = 1'b0; boundary("R10 gie off");
    check(irq == 1'b0, "R10 gie off", int'(irq), 0);
    gie = 1'b1; boundary("R4");
    check(irq == 1'b1 && idx == 3, "R4 one-cycle grant", int'(idx), 3);

    // R11: hold until ack; ack without irq ignored
    boundary("R11 hold");
    check(vec == 16'h001B, "R11 hold vec", int'(vec), 16'h1B);
    ack = 1'b1; pend = '0; tick("R11 ack");
    check(irq == 1'b0, "R11 ack drops", int'(irq), 0);

    // R5: vector of 15 and 21
    do_reset();
    en = '1; gie = 1'b1; pend[15] = 1'b1;
    boundary("R5 idx15");
    check(vec == 16'h007B, "R5 idx15", int'(vec), 16'h7B);
    do_reset();
    en = '1; gie = 1'b1; pend[21] = 1'b1;
    boundary("R5 idx21");
    check(vec == 16'h00AB, "R5 idx21", int'(vec), 16'hAB);

    // R6: reserved slot never granted, either level
    do_reset();
    en = '1; gie = 1'b1; pend[20] = 1'b1;
    boundary("R6 lo");
    prio[20] = 1'b1; boundary("R6 hi");
    check(irq == 1'b0, "R6 reserved", int'(irq), 0);

    // R13: disabled sources ignored
    do_reset();
    gie = 1'b1; pend = '1; en = '0;
    boundary("R13");
    check(irq == 1'b0, "R13 disabled", int'(irq), 0);

    // R3: level then index
    do_reset();
    en = '1; gie = 1'b1; pend[5] = 1; pend[9] = 1; pend[12] = 1;
    prio[9] = 1; prio[12] = 1;
    boundary("R3 level");
    check(idx == 9, "R3 level", int'(idx), 9);
    do_reset();
    en = '1; gie = 1'b1; pend[2] = 1; pend[7] = 1;
    boundary("R3 index");
    check(idx == 2, "R3 index", int'(idx), 2);

    // R2 / R8 / R12 / R7 nesting sequence
    do_reset();
    en = '1; gie = 1'b1; pend[4] = 1;
    boundary("R2 low grant");
    ack = 1'b1; pend[4] = 0; tick("R2 low ack");
    pend[6] = 1; boundary("R8 low held");
    check(irq == 1'b0, "R8 low held", int'(irq), 0);
    pend[10] = 1; prio[10] = 1; boundary("R2 preempt");
    check(irq == 1'b1 && idx == 10, "R2 preempt", int'(idx), 10);
    ack = 1'b1; pend[10] = 0; tick("R2 hi ack");
    pend[11] = 1; prio[11] = 1; boundary("R2 hi blocks");
    check(irq == 1'b0, "R2 hi blocks", int'(irq), 0);
    reti = 1'b1; boundary("R7 no grant on return");
    check(irq == 1'b0, "R7 return boundary", int'(irq), 0);
    boundary("R7 one instr later");
    check(irq == 1'b1 && idx == 11, "R12 hi cleared lo kept", int'(idx), 11);
    ack = 1'b1; pend[11] = 0; tick("R12 ack");
    reti = 1'b1; boundary("R12 unwind hi");
    boundary("R12 lo still busy");
    check(irq == 1'b0, "R12 lo still busy", int'(irq), 0);
    reti = 1'b1; boundary("R12 unwind lo");
    boundary("R8 released");
    check(irq == 1'b1 && idx == 6, "R8 released", int'(idx), 6);

    // R9: stall holds off, then grants
    do_reset();
    en = '1; gie = 1'b1; stall = 1'b1; pend[8] = 1;
    boundary("R9 stall");
    boundary("R9 stall");
    check(irq == 1'b0, "R9 stalled", int'(irq), 0);
    stall = 1'b0; boundary("R9 released");
    check(irq == 1'b1 && idx == 8, "R9 released", int'(idx), 8);

    // Random mix against the model (R2 R3 R8 R11 R12 R13)
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < N; i++) begin
        pend[i] = ($urandom % 8) == 0;
        en[i]   = ($urandom % 6) != 0;
        prio[i] = ($urandom % 3) == 0;
      end
      gie   = ($urandom % 10) != 0;
      idone = ($urandom % 2) == 0;
      stall = ($urandom % 10) == 0;
      ack   = ($urandom % 3) == 0;
      reti  = idone && (m_hi || m_lo) && (($urandom % 5) == 0);
      tick("R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule